// File: doc/BRIEF.md
# External Interrupt Priority Arbiter

This block sits between six external interrupt lines and a processor core. It samples each line once per clock. Reset, stop-clock and the maskable interrupt are taken as levels. System-management, init and non-maskable are taken as rising edges. Each edge source keeps a single-bit pending latch.

A pending edge source is only eligible while its own block flag is clear. The maskable interrupt is only eligible while the core's interrupt-enable flag is 1. A fixed priority picks one winner, which is presented to the core as a one-hot request with a valid bit.

The core acknowledges the presented request. The acknowledge clears the serviced latch and drops the request for one cycle, after which a new winner may be presented. Servicing the non-maskable interrupt blocks further non-maskable interrupts until the core signals an interrupt return. All three block flags can also be set or cleared directly through dedicated strobes.

Top module: `ext_irq_arbiter`

## Requirements
- R1: Source bit positions in `irq_i` and `req_o` are 0 reset, 1 stop-clock, 2 system-management, 3 init, 4 non-maskable and 5 maskable. Among eligible sources, the lowest bit position wins.
- R2: A rising edge on bit 2, 3 or 4 is recognised even if the line is high for a single clock. A line that goes high before clock edge k is presented on `req_o` after edge k+1 if it is eligible and the output is idle.
- R3: Bits 0, 1 and 5 are level-sensitive and are never latched. A maskable line that drops before it is presented leaves no request behind, and a level line still high after its acknowledge is presented again.
- R4: Bit 5 is eligible only while `if_flag_i` is 1. Bits 0 and 1 are eligible regardless of `if_flag_i` and the block flags.
- R5: Block flag bit 0 governs system-management, bit 1 init and bit 2 non-maskable. While a source is blocked, one edge is held pending and further edges are lost. The held edge is presented once the flag clears.
- R6: A higher-priority pending source wins even if a lower-priority source became pending earlier.
- R7: `req_o` is one-hot or zero, and `req_valid_o` is 1 exactly when it is nonzero. While `req_valid_o` is 1 and `ack_i` is 0, `req_o` does not change, even if a higher-priority source arrives.
- R8: When `ack_i` is 1 while `req_valid_o` is 1, `req_o` goes to zero after that edge and the serviced source's pending latch clears. The next winner is presented one edge later.
- R9: Acknowledging a non-maskable request sets block flag bit 2, and `iret_i` clears it. `blk_set_i` and `blk_clr_i` set and clear flag bits directly, and a set wins over a clear in the same cycle.
- R10: Asserting `rst_ni` low clears the output, all pending latches and all block flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 6 | Raw interrupt lines, bit order per R1 |
| if_flag_i | input | 1 | Core interrupt-enable flag |
| iret_i | input | 1 | Interrupt-return strobe, clears the non-maskable block flag |
| blk_set_i | input | 3 | Block flag set strobes (SMI, INIT, NMI) |
| blk_clr_i | input | 3 | Block flag clear strobes (SMI, INIT, NMI) |
| ack_i | input | 1 | Core service acknowledge for the presented request |
| req_o | output | 6 | One-hot winning source |
| req_valid_o | output | 1 | Request present |

## Verification
The assertions check the following on every cycle:
- the one-hot form of the output;
- that the output holds while it is unacknowledged;
- that it drops after an acknowledge;
- that a non-maskable acknowledge leaves the source blocked;
- that a maskable request is only loaded with the enable flag set;
- that pending latches persist until cleared.

The bench's scenarios show the following:
- the full priority order;
- the single-occurrence behaviour of a blocked source, where a second edge is lost;
- a later high-priority arrival overtaking an earlier low-priority one;
- the non-latching of a short maskable pulse;
- the clearing of held state by reset.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NSRC      = 6;
  localparam int IDX_RESET = 0;
  localparam int IDX_STPCK = 1;
  localparam int IDX_SMI   = 2;
  localparam int IDX_INIT  = 3;
  localparam int IDX_NMI   = 4;
  localparam int IDX_INTR  = 5;
  localparam int BLK_BASE  = IDX_SMI;
  localparam int NBLK      = IDX_NMI - IDX_SMI + 1;
  localparam int BLK_NMI   = IDX_NMI - BLK_BASE;
  localparam logic [NSRC-1:0] EDGE_MASK = 6'b011100;
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int              N         = 6,
  parameter logic [N-1:0]    EDGE_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] smp_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) smp_q <= '0;
    else         smp_q <= raw_i;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= smp_q[i];
      assign evt_o[i] = smp_q[i] & ~prev_q;

      AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o[i] |=> !evt_o[i]); // R2
    end else begin : g_level
      assign evt_o[i] = smp_q[i];
    end
  end
endmodule

// File: rtl/irq_pend_cell.sv
module irq_pend_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  // new edge wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    pend_q <= 1'b0;
    else if (evt_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;

  assign pend_o = pend_q;

  AST_PEND_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !clr_i |=> pend_q); // R5
  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> pend_q); // R2
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ext_irq_arbiter.sv
module ext_irq_arbiter
  import ext_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] irq_i,
  input  logic            if_flag_i,
  input  logic            iret_i,
  input  logic [NBLK-1:0] blk_set_i,
  input  logic [NBLK-1:0] blk_clr_i,
  input  logic            ack_i,
  output logic [NSRC-1:0] req_o,
  output logic            req_valid_o
);
  logic [NSRC-1:0] evt, act, gnt, req_q;
  logic [NBLK-1:0] blk_q, blk_d;
  logic            ack_take;

  assign ack_take    = ack_i & req_valid_o;
  assign req_o       = req_q;
  assign req_valid_o = |req_q;

  irq_sampler #(.N(NSRC), .EDGE_MASK(EDGE_MASK)) u_smp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (irq_i),
    .evt_o (evt)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      logic pend;
      irq_pend_cell u_pend (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .evt_i (evt[i]),
        .clr_i (ack_take & req_q[i]),
        .pend_o(pend)
      );
      assign act[i] = (pend | evt[i]) & ~blk_q[i-BLK_BASE];
    end else if (i == IDX_INTR) begin : g_mask
      assign act[i] = evt[i] & if_flag_i;
    end else begin : g_level
      assign act[i] = evt[i];
    end
  end

  irq_prio_pick #(.N(NSRC)) u_pick (
    .req_i(act),
    .gnt_o(gnt)
  );

  // block flags: set wins over clear
  always_comb begin
    logic [NBLK-1:0] set_v, clr_v;
    set_v = blk_set_i;
    clr_v = blk_clr_i;
    set_v[BLK_NMI] = set_v[BLK_NMI] | (ack_take & req_q[IDX_NMI]);
    clr_v[BLK_NMI] = clr_v[BLK_NMI] | iret_i;
    blk_d = set_v | (blk_q & ~clr_v);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) blk_q <= '0;
    else         blk_q <= blk_d;

  // output holds until acknowledged, then idles one cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)           req_q <= '0;
    else if (ack_take)     req_q <= '0;
    else if (!req_valid_o) req_q <= gnt;

  AST_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_o)); // R7
  AST_HOLD_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !ack_i |=> $stable(req_o)); // R7
  AST_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && req_valid_o |=> !req_valid_o); // R8
  AST_NMI_SELF_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && req_o[IDX_NMI] |=> blk_q[BLK_NMI]); // R9
  AST_INTR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o[IDX_INTR]) |-> $past(if_flag_i)); // R4
endmodule

// File: tb/ext_irq_arbiter_test.sv
module ext_irq_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] irq = '0;
  logic       ifl = 1'b0;
  logic       iret = 1'b0;
  logic [2:0] bset = '0;
  logic [2:0] bclr = '0;
  logic       ack = 1'b0;
  logic [5:0] req;
  logic       vld;
  int checks = 0;
  int errors = 0;

  localparam logic [5:0] EDGES = 6'b011100;
  // {lines[5:0], if_flag, block[2:0], expected[5:0]}
  localparam int NV = 13;
  localparam logic [15:0] VEC [NV] = '{
    16'b000000_1_000_000000,
    16'b100000_1_000_100000,
    16'b100000_0_000_000000,
    16'b110000_1_000_010000,
    16'b011100_1_000_000100,
    16'b011000_1_000_001000,
    16'b000110_1_000_000010,
    16'b111111_1_000_000001,
    16'b010100_1_001_010000,
    16'b110000_1_100_100000,
    16'b011100_0_111_000000,
    16'b011110_0_111_000010,
    16'b101000_1_010_100000
  };

  always #4 clk = ~clk;

  ext_irq_arbiter uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .if_flag_i(ifl), .iret_i(iret),
    .blk_set_i(bset), .blk_clr_i(bclr), .ack_i(ack), .req_o(req), .req_valid_o(vld)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [5:0] exp);
    checks++;
    if (req !== exp || vld !== (|exp)) begin
      errors++;
      $display("FAIL %s req=%b vld=%b expected req=%b vld=%b", tag, req, vld, exp, |exp);
    end
  endtask

  task automatic do_reset();
    irq = '0; ifl = 1'b0; iret = 1'b0; bset = '0; bclr = '0; ack = 1'b0;
    rst_n = 1'b0; tick(1); rst_n = 1'b1; tick(1);
  endtask

  task automatic pulse(input logic [5:0] lines);
    irq = irq | lines; tick(1); irq = irq & ~lines; tick(1);
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(1); ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(1);
    chk("R10 reset state", 6'b0);
    rst_n = 1'b1; tick(1);

    // R1 R4 R5 priority table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      bset = VEC[v][8:6]; tick(1); bset = '0;
      ifl = VEC[v][9];
      irq = VEC[v][15:10]; tick(1);
      irq = irq & ~EDGES; tick(1);
      chk($sformatf("R1 vector %0d", v), VEC[v][5:0]);
    end

    // R5 single occurrence while blocked
    do_reset();
    bset = 3'b100; tick(1); bset = '0;
    pulse(6'b010000); tick(1);
    chk("R5 blocked nmi not presented", 6'b0);
    pulse(6'b010000);
    bclr = 3'b100; tick(1); bclr = '0; tick(1);
    chk("R5 held nmi presented on unblock", 6'b010000);
    do_ack();
    chk("R8 request dropped after ack", 6'b0);
    bclr = 3'b100; tick(1); bclr = '0; tick(1);
    chk("R5 second nmi edge lost", 6'b0);

    // R9 ack blocks nmi, iret unblocks
    pulse(6'b010000);
    chk("R2 single-cycle nmi presented", 6'b010000);
    do_ack();
    pulse(6'b010000); tick(2);
    chk("R9 nmi blocked after its ack", 6'b0);
    iret = 1'b1; tick(1); iret = 1'b0; tick(1);
    chk("R9 iret unblocks nmi", 6'b010000);
    do_ack();

    // R9 set wins over clear
    do_reset();
    bset = 3'b100; bclr = 3'b100; tick(1); bset = '0; bclr = '0;
    pulse(6'b010000); tick(1);
    chk("R9 set wins over clear", 6'b0);

    // R7 hold, R6 priority after ack, R3 level re-presented
    do_reset();
    ifl = 1'b1; irq = 6'b100000; tick(2);
    chk("R3 intr presented", 6'b100000);
    pulse(6'b000100); tick(1);
    chk("R7 output held despite smi", 6'b100000);
    do_ack();
    chk("R8 idle after ack", 6'b0);
    tick(1);
    chk("R6 smi wins next", 6'b000100);
    do_ack(); tick(1);
    chk("R3 intr re-presented while held", 6'b100000);
    irq = '0; do_ack(); tick(2);
    chk("R3 intr gone after line drops", 6'b0);

    // R3 short maskable pulse not latched
    do_reset();
    irq = 6'b100000; tick(1); irq = '0; tick(1);
    ifl = 1'b1; tick(3);
    chk("R3 short intr not latched", 6'b0);

    // R6 later higher-priority arrival overtakes earlier lower one
    do_reset();
    bset = 3'b101; tick(1); bset = '0;
    pulse(6'b010000); tick(1);
    pulse(6'b000100); tick(1);
    chk("R6 both blocked", 6'b0);
    bclr = 3'b101; tick(1); bclr = '0; tick(1);
    chk("R6 smi beats earlier nmi", 6'b000100);
    do_ack();
    chk("R8 idle between grants", 6'b0);
    tick(1);
    chk("R8 nmi follows smi", 6'b010000);

    // R10 reset clears pending and blocks
    do_reset();
    bset = 3'b001; tick(1); bset = '0;
    pulse(6'b000100);
    rst_n = 1'b0; tick(1); rst_n = 1'b1; tick(3);
    chk("R10 pending cleared by reset", 6'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule